// File: doc/BRIEF.md
# T1 Frame Alignment Search

This block finds frame alignment in a received DS1 bit stream made of frames of `FRAME_BITS` bits (193 by default). It tests every candidate bit position in parallel and keeps state for each one in a small memory. The memory is addressed by a free-running bit counter, so exactly one candidate is updated per received bit.

In D4 mode, candidates span two frames. The terminal framing bits alternate 1, 0. In extended-superframe mode, candidates span four frames and the framing bits follow 0, 0, 1, 0, 1, 1. Each candidate keeps the last three of its samples and uses them to predict the next one. A candidate that misses the prediction is dropped.

The search decides at two points. After ten samples per candidate, a single survivor is locked. If several survive until the twenty-fourth sample, the next survivor that arrives is locked. Once locked, the frame strobe follows the new position. In D4 mode the block then looks for the multiframe pattern in the signaling framing bit, which sits one frame away from the chosen position.

The controller states are:
- `ST_WAIT`: waiting for the search start position.
- `ST_SEARCH`: winnowing candidates.
- `ST_CONFIRM`: D4 with cross-check, where the frame is chosen but the multiframe pattern is still pending.
- `ST_LOCKED`: in frame.

The transitions are:
- WAIT→SEARCH when the start bit arrives.
- SEARCH→LOCKED, or SEARCH→CONFIRM when cross-check is on, at lock.
- CONFIRM→LOCKED when the multiframe pattern is found.
- LOCKED→WAIT and CONFIRM→WAIT on a reframe request.

Top module: `t1_frame_aligner`

## Requirements
- R1: Each candidate holds a 3-sample history (oldest in bit 2). Its third sample must complete a valid triple: 010 or 101 in D4, anything but 000 or 111 in extended-superframe mode. From the fourth sample on, a candidate is dropped when its sample differs from the prediction. In D4 the prediction is the inverse of the newest sample. In extended-superframe mode it is 001→0, 010→1, 101→1, 011→0, 110→0, 100→1.
- R2: When exactly one candidate survives a completed pass with at least 10 samples, the block locks on the last bit of that pass. From then on, `frame_sync` pulses on every bit whose index modulo `FRAME_BITS` equals the locked position modulo `FRAME_BITS`.
- R3: When no candidate survives a completed pass with at least 10 samples, the search restarts with fresh candidates on the next bit.
- R4: When two or more candidates survive through 24 samples, the first surviving candidate seen during a later pass is locked on that bit.
- R5: A `reframe` pulse drops `in_frame`. The new search starts at the position one after the previously locked position, which means a mimic locked earlier is passed over.
- R6: In D4 mode, the multiframe bit sits `FRAME_BITS` positions from the locked position. `mf_aligned` sets on the history 00111, or on 000111000111 when `slc_mode` is set. `mf_sync` pulses on the multiframe bit that starts each 6-sample or 12-sample cycle. In extended-superframe mode, `mf_aligned` stays low.
- R7: In D4 mode with `xchk_en` set, `in_frame` and `mf_aligned` rise on the same clock edge, after the multiframe pattern is found.
- R8: An `mf_reframe` pulse clears `mf_aligned` and restarts the multiframe search, while `in_frame` and `frame_sync` are left unchanged.
- R9: `sig_freeze` and `err_suspend` are high whenever `in_frame` is low. During a reframe, `frame_sync` keeps running on the last alignment.
- R10: `frame_sync` and `mf_sync` are only high while `bit_en` is high.
- R11: After reset, `in_frame` and `mf_aligned` are low, `sig_freeze` and `err_suspend` are high, and the first search starts at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | A received bit is present on `rx_bit` this cycle |
| rx_bit | input | 1 | Serial line data |
| esf_mode | input | 1 | 1: extended superframe, 0: D4 |
| xchk_en | input | 1 | D4: align frame and multiframe together |
| slc_mode | input | 1 | D4: use the 12-sample multiframe pattern |
| reframe | input | 1 | Request a new frame search |
| mf_reframe | input | 1 | Request a new multiframe search only |
| frame_sync | output | 1 | Strobe on the framing bit of each frame |
| mf_sync | output | 1 | Strobe on the multiframe start bit |
| in_frame | output | 1 | Frame alignment is valid |
| mf_aligned | output | 1 | Multiframe alignment is valid |
| sig_freeze | output | 1 | Hold signaling while out of frame |
| err_suspend | output | 1 | Suspend framing-error counting while out of frame |

## Verification
On every cycle, the assertions check the following:
- Strobes appear only with a bit.
- The multiframe strobe lands on a frame strobe.
- A reframe drops both alignments, while a multiframe reframe keeps frame alignment.
- With cross-check on, frame and multiframe rise together.
- Extended-superframe mode never gains multiframe alignment.

Only the bench scenarios can show that the winnowing picks the right position, and on which exact bit the lock happens at the 10-sample point, the 24-sample point and after a restart. They also show that a reframe moves past a locked mimic, and that the strobe phases are correct for every candidate position in both modes.

// File: rtl/fa_pkg.sv
package fa_pkg;

    typedef enum logic [1:0] {
        ST_WAIT    = 2'd0,
        ST_SEARCH  = 2'd1,
        ST_CONFIRM = 2'd2,
        ST_LOCKED  = 2'd3
    } fa_state_t;

    typedef struct packed {
        logic       alive;
        logic [2:0] hist;   // bit 2 oldest sample
    } cand_t;

    // next framing sample expected after history h
    function automatic logic pred_next(input logic esf, input logic [2:0] h);
        logic p;
        if (!esf) begin
            p = ~h[0];
        end else begin
            unique case (h)
                3'b010, 3'b101, 3'b100: p = 1'b1;
                default:                p = 1'b0;
            endcase
        end
        return p;
    endfunction

    // whether a triple can occur inside the framing pattern
    function automatic logic hist_ok(input logic esf, input logic [2:0] h);
        if (esf) return (h != 3'b000) && (h != 3'b111);
        return (h == 3'b010) || (h == 3'b101);
    endfunction

endpackage

// File: rtl/fa_cand_store.sv
module fa_cand_store
    import fa_pkg::*;
#(
    parameter int DEPTH = 772,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  cand_t         wdata,
    input  logic [AW-1:0] raddr,
    output cand_t         rdata
);
    cand_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/fa_mf_detect.sv
module fa_mf_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sample,
    input  logic fs_bit,
    input  logic slc,
    input  logic clear,
    output logic found,
    output logic aligned,
    output logic mf_sync
);
    logic [11:0] hist;
    logic [11:0] hist_nx;
    logic [3:0]  cnt;
    logic [3:0]  idx;
    logic [3:0]  idx_last;
    logic        match;

    assign hist_nx  = {hist[10:0], fs_bit};
    assign idx_last = slc ? 4'd11 : 4'd5;
    assign match    = slc ? ((cnt >= 4'd11) && (hist_nx == 12'b000111000111))
                          : ((cnt >= 4'd4)  && (hist_nx[4:0] == 5'b00111));
    assign found    = en && sample && !aligned && match;
    assign mf_sync  = en && sample && aligned && (idx == idx_last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist    <= '0;
            cnt     <= '0;
            idx     <= '0;
            aligned <= 1'b0;
        end else if (clear) begin
            hist    <= '0;
            cnt     <= '0;
            idx     <= '0;
            aligned <= 1'b0;
        end else if (en && sample) begin
            hist <= hist_nx;
            if (cnt != 4'd12) cnt <= cnt + 4'd1;
            if (found) begin
                aligned <= 1'b1;
                idx     <= slc ? 4'd11 : 4'd4;
            end else if (aligned) begin
                idx <= (idx == idx_last) ? 4'd0 : idx + 4'd1;
            end
        end
    end
endmodule

// File: rtl/t1_frame_aligner.sv
module t1_frame_aligner
    import fa_pkg::*;
#(
    parameter int FRAME_BITS     = 193,
    parameter int LOCK_ROUNDS    = 10,
    parameter int TIMEOUT_ROUNDS = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic rx_bit,
    input  logic esf_mode,
    input  logic xchk_en,
    input  logic slc_mode,
    input  logic reframe,
    input  logic mf_reframe,
    output logic frame_sync,
    output logic mf_sync,
    output logic in_frame,
    output logic mf_aligned,
    output logic sig_freeze,
    output logic err_suspend
);
    localparam int SPAN_MAX = 4 * FRAME_BITS;
    localparam int AW       = $clog2(SPAN_MAX);
    localparam int FW       = $clog2(FRAME_BITS);
    localparam int RW       = $clog2(TIMEOUT_ROUNDS + 1);

    fa_state_t state, state_nx;

    logic [AW-1:0] pos, k, start_pos, lock_pos, fs_pos, last_pos, span_last;
    logic [FW-1:0] fpos, lock_fpos, last_fpos;
    logic [RW-1:0] round;
    logic [1:0]    surv, cnt_in, cnt_now;
    logic          have_align;

    cand_t         rd, wr;
    logic [2:0]    cur_hist, new_hist;
    logic          fresh, cur_alive, ok, alive_now, act, end_round;
    logic          late_lock, decide, single, restart, do_lock;
    logic [AW-1:0] pick_pos, pick_fs;
    logic [FW-1:0] pick_fpos;
    logic          mf_found, mf_en, fs_sample, mf_clear;

    assign span_last = esf_mode ? AW'(4 * FRAME_BITS - 1) : AW'(2 * FRAME_BITS - 1);

    // ---------------- candidate evaluation ----------------
    assign act       = bit_en && ((state == ST_SEARCH) ||
                                  ((state == ST_WAIT) && (pos == start_pos)));
    assign fresh     = (state == ST_WAIT) || (round == '0);
    assign cur_hist  = fresh ? 3'b000 : rd.hist;
    assign cur_alive = fresh ? 1'b1 : rd.alive;
    assign new_hist  = {cur_hist[1:0], rx_bit};

    always_comb begin
        if (fresh || (round < RW'(2)))  ok = 1'b1;
        else if (round == RW'(2))        ok = hist_ok(esf_mode, new_hist);
        else                             ok = (rx_bit == pred_next(esf_mode, cur_hist));
    end

    assign alive_now = cur_alive && ok;
    assign end_round = (k == span_last);
    assign cnt_in    = (k == '0) ? 2'd0 : surv;
    assign cnt_now   = (cnt_in == 2'd2) ? 2'd2 : cnt_in + {1'b0, alive_now};
    assign pick_pos  = alive_now ? pos  : last_pos;
    assign pick_fpos = alive_now ? fpos : last_fpos;
    assign pick_fs   = (pick_pos >= AW'(FRAME_BITS)) ? pick_pos - AW'(FRAME_BITS)
                                                     : pick_pos + AW'(FRAME_BITS);

    assign late_lock = act && !fresh && (round == RW'(TIMEOUT_ROUNDS)) && alive_now;
    assign decide    = act && !fresh && end_round && (round >= RW'(LOCK_ROUNDS - 1));
    assign single    = decide && (cnt_now == 2'd1) && !late_lock;
    assign restart   = decide && (cnt_now == 2'd0);
    assign do_lock   = (state == ST_SEARCH) && (late_lock || single);

    assign wr = '{alive: alive_now, hist: new_hist};

    fa_cand_store #(.DEPTH(SPAN_MAX), .AW(AW)) u_store (
        .clk   (clk),
        .we    (act),
        .waddr (pos),
        .wdata (wr),
        .raddr (pos),
        .rdata (rd)
    );

    // ---------------- multiframe search ----------------
    assign mf_en     = !esf_mode && ((state == ST_CONFIRM) || (state == ST_LOCKED));
    assign fs_sample = bit_en && (pos == fs_pos);
    assign mf_clear  = do_lock || reframe || mf_reframe;

    fa_mf_detect u_mf (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (mf_en),
        .sample  (fs_sample),
        .fs_bit  (rx_bit),
        .slc     (slc_mode),
        .clear   (mf_clear),
        .found   (mf_found),
        .aligned (mf_aligned),
        .mf_sync (mf_sync)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_WAIT;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WAIT:    if (act) state_nx = ST_SEARCH;
            ST_SEARCH:  if (do_lock) state_nx = (xchk_en && !esf_mode) ? ST_CONFIRM : ST_LOCKED;
            ST_CONFIRM: if (reframe) state_nx = ST_WAIT;
                        else if (mf_found) state_nx = ST_LOCKED;
            ST_LOCKED:  if (reframe) state_nx = ST_WAIT;
            default:    state_nx = ST_WAIT;
        endcase
    end

    // ---------------- counters and lock registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos        <= '0;
            fpos       <= '0;
            k          <= '0;
            round      <= '0;
            surv       <= '0;
            last_pos   <= '0;
            last_fpos  <= '0;
            start_pos  <= '0;
            lock_pos   <= '0;
            lock_fpos  <= '0;
            fs_pos     <= '0;
            have_align <= 1'b0;
        end else begin
            if (bit_en) begin
                pos  <= (pos == span_last) ? '0 : pos + AW'(1);
                fpos <= (fpos == FW'(FRAME_BITS - 1)) ? '0 : fpos + FW'(1);
            end
            if (state != ST_SEARCH) begin
                k     <= '0;
                round <= '0;
            end
            if (act) begin
                k    <= end_round ? '0 : k + AW'(1);
                surv <= cnt_now;
                if (alive_now) begin
                    last_pos  <= pos;
                    last_fpos <= fpos;
                end
                if (end_round) begin
                    if (restart)                                round <= '0;
                    else if (round != RW'(TIMEOUT_ROUNDS))      round <= round + RW'(1);
                end
            end
            if (do_lock) begin
                lock_pos   <= pick_pos;
                lock_fpos  <= pick_fpos;
                fs_pos     <= pick_fs;
                have_align <= 1'b1;
            end
            if (reframe && ((state == ST_LOCKED) || (state == ST_CONFIRM)))
                start_pos <= (lock_pos == span_last) ? '0 : lock_pos + AW'(1);
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        in_frame    = (state == ST_LOCKED);
        sig_freeze  = (state != ST_LOCKED);
        err_suspend = (state != ST_LOCKED);
        frame_sync  = bit_en && have_align && (fpos == lock_fpos);
    end
endmodule

// File: rtl/t1_frame_aligner_chk.sv
module t1_frame_aligner_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic esf_mode,
    input logic xchk_en,
    input logic reframe,
    input logic mf_reframe,
    input logic frame_sync,
    input logic mf_sync,
    input logic in_frame,
    input logic mf_aligned
);
    AST_STROBE_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_sync || mf_sync) |-> bit_en) else $error("strobe without bit"); // R10

    AST_MF_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        mf_sync |-> frame_sync) else $error("mf strobe off frame"); // R6

    AST_XCHK_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(in_frame) && xchk_en && $past(xchk_en) && !esf_mode && !$past(esf_mode))
        |-> mf_aligned) else $error("cross-check rise split"); // R7

    AST_MF_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        mf_aligned |-> in_frame) else $error("multiframe without frame"); // R7

    AST_MFRF_KEEPS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame && mf_reframe && !reframe) |=> (in_frame && !mf_aligned))
        else $error("mf reframe touched frame"); // R8

    AST_REFRAME_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame && reframe) |=> (!in_frame && !mf_aligned))
        else $error("reframe kept alignment"); // R5

    AST_ESF_NO_MF: assert property (@(posedge clk) disable iff (!rst_n)
        (esf_mode && $past(esf_mode) && !$past(mf_aligned)) |-> !mf_aligned)
        else $error("multiframe in esf"); // R6
endmodule

bind t1_frame_aligner t1_frame_aligner_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .esf_mode   (esf_mode),
    .xchk_en    (xchk_en),
    .reframe    (reframe),
    .mf_reframe (mf_reframe),
    .frame_sync (frame_sync),
    .mf_sync    (mf_sync),
    .in_frame   (in_frame),
    .mf_aligned (mf_aligned)
);

// File: tb/t1_frame_aligner_tb.sv
module t1_frame_aligner_tb;
    localparam int F = 5;

    logic clk = 1'b0;
    logic rst_n, bit_en, rx_bit, esf_mode, xchk_en, slc_mode, reframe, mf_reframe;
    logic frame_sync, mf_sync, in_frame, mf_aligned, sig_freeze, err_suspend;

    always #5 clk = ~clk;

    t1_frame_aligner #(.FRAME_BITS(F)) u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
        .esf_mode(esf_mode), .xchk_en(xchk_en), .slc_mode(slc_mode),
        .reframe(reframe), .mf_reframe(mf_reframe),
        .frame_sync(frame_sync), .mf_sync(mf_sync), .in_frame(in_frame),
        .mf_aligned(mf_aligned), .sig_freeze(sig_freeze), .err_suspend(err_suspend)
    );

    int n_chk = 0;
    int n_bad = 0;
    int t = 0;
    int g_a, g_b, g_ones;
    bit m_fs, m_mf, m_x;
    int m_ph;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (bit %0d)", req, act, exp, t);
        end
    endtask

    function automatic int span();
        return esf_mode ? 4 * F : 2 * F;
    endfunction

    // framing bit value for sample index q of a candidate
    function automatic logic ft_val(int q);
        if (esf_mode) return ((q % 6) == 2) || ((q % 6) == 4) || ((q % 6) == 5);
        return (q % 2) == 0;
    endfunction

    function automatic logic gen(int tt);
        int p, q;
        p = tt % span();
        q = tt / span();
        if (tt < g_ones) return 1'b1;
        if (p == g_a || p == g_b) return ft_val(q);
        if (!esf_mode && p == (g_a + F) % span()) begin
            if (slc_mode) return (q % 6) >= 3;
            return ((q % 6) >= 2) && ((q % 6) <= 4);
        end
        return 1'b1;
    endfunction

    task automatic step_bit();
        int p, q, per;
        @(negedge clk);
        if ((t % 3) == 2) begin
            bit_en = 1'b0;
            rx_bit = ~rx_bit;
            #1;
            chk("R10 frame_sync idle", int'(frame_sync), 0);
            chk("R10 mf_sync idle", int'(mf_sync), 0);
            @(negedge clk);
        end
        bit_en = 1'b1;
        rx_bit = gen(t);
        #1;
        p   = t % span();
        q   = t / span();
        per = slc_mode ? 12 : 6;
        if (m_fs) chk("R2 frame_sync phase", int'(frame_sync), int'((t % F) == m_ph));
        if (m_mf) chk("R6 mf_sync phase", int'(mf_sync),
                      int'(p == (g_a + F) % span() && (q % per) == 0));
        if (m_x)  chk("R7 rise together", int'(in_frame), int'(mf_aligned));
        t++;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step_bit();
        @(negedge clk);
        bit_en = 1'b0;
        #1;
    endtask

    task automatic do_reset(bit esf, bit x, bit slc, int a, int b, int ones);
        rst_n = 1'b0; bit_en = 1'b0; rx_bit = 1'b0; reframe = 1'b0; mf_reframe = 1'b0;
        esf_mode = esf; xchk_en = x; slc_mode = slc;
        g_a = a; g_b = b; g_ones = ones;
        m_fs = 1'b0; m_mf = 1'b0; m_x = 1'b0; m_ph = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t = 0;
        #1;
    endtask

    task automatic pulse_reframe(bit mf);
        @(negedge clk);
        if (mf) mf_reframe = 1'b1; else reframe = 1'b1;
        @(negedge clk);
        reframe = 1'b0; mf_reframe = 1'b0;
        #1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int s;
        // R11 reset state
        do_reset(1'b0, 1'b0, 1'b0, 0, -1, 0);
        chk("R11 in_frame", int'(in_frame), 0);
        chk("R11 mf_aligned", int'(mf_aligned), 0);
        chk("R11 sig_freeze", int'(sig_freeze), 1);
        chk("R11 err_suspend", int'(err_suspend), 1);
        chk("R11 frame_sync", int'(frame_sync), 0);

        // D4, Ft only: every alignment, normal multiframe
        for (int a = 0; a < 2 * F; a++) begin
            do_reset(1'b0, 1'b0, 1'b0, a, -1, 0);
            s = 2 * F;
            run(10 * s - 1);
            chk("R1 no lock before tenth sample", int'(in_frame), 0);
            run(1);
            chk("R2 lock after ten samples", int'(in_frame), 1);
            chk("R6 multiframe separate", int'(mf_aligned), 0);
            chk("R9 freeze released", int'(sig_freeze | err_suspend), 0);
            m_fs = 1'b1; m_ph = a % F;
            run(8 * s);
            chk("R6 multiframe found", int'(mf_aligned), 1);
            m_mf = 1'b1;
            run(12 * s);
        end

        // ESF: every alignment, no multiframe
        for (int a = 0; a < 4 * F; a++) begin
            do_reset(1'b1, 1'b0, 1'b0, a, -1, 0);
            s = 4 * F;
            run(10 * s - 1);
            chk("R1 esf no early lock", int'(in_frame), 0);
            run(1);
            chk("R2 esf lock", int'(in_frame), 1);
            m_fs = 1'b1; m_ph = a % F;
            run(8 * s);
            chk("R6 esf no multiframe", int'(mf_aligned), 0);
        end

        // D4 cross-check: frame and multiframe together
        for (int a = 0; a < 2 * F; a++) begin
            do_reset(1'b0, 1'b1, 1'b0, a, -1, 0);
            s = 2 * F;
            m_x = 1'b1;
            run(10 * s);
            chk("R7 waits for multiframe", int'(in_frame), 0);
            run(12 * s);
            chk("R7 in_frame", int'(in_frame), 1);
            chk("R7 mf_aligned", int'(mf_aligned), 1);
        end

        // SLC-96 multiframe pattern
        for (int a = 0; a < 2 * F; a++) begin
            do_reset(1'b0, 1'b0, 1'b1, a, -1, 0);
            s = 2 * F;
            run(10 * s);
            chk("R2 slc frame lock", int'(in_frame), 1);
            run(26 * s);
            chk("R6 slc multiframe", int'(mf_aligned), 1);
            m_mf = 1'b1; m_fs = 1'b1; m_ph = a % F;
            run(24 * s);
        end

        // R3 restart when nothing survives
        do_reset(1'b0, 1'b0, 1'b0, 3, -1, 12 * 2 * F);
        run(30 * 2 * F - 1);
        chk("R3 no lock yet", int'(in_frame), 0);
        run(1);
        chk("R3 lock after restart", int'(in_frame), 1);

        // R4 timeout with a mimic, then R5 reframe skips it
        do_reset(1'b0, 1'b0, 1'b0, 1, 4, 0);
        s = 2 * F;
        run(24 * s + 1);
        chk("R4 no lock while two survive", int'(in_frame), 0);
        run(1);
        chk("R4 lock on first survivor", int'(in_frame), 1);
        m_fs = 1'b1; m_ph = 1;
        run(4 * s);
        pulse_reframe(1'b0);
        chk("R5 reframe drops in_frame", int'(in_frame), 0);
        chk("R9 sig_freeze", int'(sig_freeze), 1);
        chk("R9 err_suspend", int'(err_suspend), 1);
        run(s);  // R9 strobe continues on old phase
        m_fs = 1'b0;
        run(26 * s);
        chk("R5 relock", int'(in_frame), 1);
        m_fs = 1'b1; m_ph = 4;
        run(4 * s);

        // R8 multiframe reframe only
        do_reset(1'b0, 1'b0, 1'b0, 0, -1, 0);
        s = 2 * F;
        run(20 * s);
        chk("R8 mf before", int'(mf_aligned), 1);
        pulse_reframe(1'b1);
        chk("R8 mf cleared", int'(mf_aligned), 0);
        chk("R8 frame kept", int'(in_frame), 1);
        m_fs = 1'b1; m_ph = 0;
        run(14 * s);
        chk("R8 mf regained", int'(mf_aligned), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule